// File: doc/BRIEF.md
# Priority Task Dispatcher with Age Ordering

This block tracks the life cycle of a small fixed set of tasks and decides, every clock cycle, which single task owns the processor. Each task carries a static priority, latched while reset is held. Tasks move between four states (suspended, ready, running, waiting) in response to commands on a one-command-per-cycle port. The block has no processor behind it. It only keeps the states and produces the dispatch decision.

The ready task with the largest priority value is chosen. Among ready tasks of equal priority, the one that joined the ready set earliest wins. Scheduling is fully preemptive: a ready task of strictly higher priority displaces the running one. The displaced task goes back to ready at the tail of its priority group, and a one-cycle pulse reports the displacement. A command that does not fit the current state of its task changes nothing and raises an error flag for one cycle.

Top module: `task_scheduler`

## Requirements
- R1: While `rst` is high, every task becomes suspended, `run_valid`, `preempt` and `cmd_err` go low, and each task's priority is taken from `prio_init` (task i at bits [i*PRIO_W +: PRIO_W]; a larger value means higher priority).
- R2: A command is applied when `cmd_valid` is high at a rising edge. `cmd_op` encodes 0 = activate, 1 = terminate, 2 = wait, 3 = release. Activate moves a suspended task to ready.
- R3: At most one task is running. `run_valid` and `run_id` report it and reflect the command of the same edge, so they are visible after that edge.
- R4: When the processor is free, the ready task with the largest priority value starts running.
- R5: Among ready tasks of equal priority, the task that entered ready earliest is chosen.
- R6: A ready task of strictly higher priority preempts the running task. `preempt` is high for exactly the cycle after that edge. A ready task of equal or lower priority never preempts.
- R7: A preempted task returns to ready as the youngest member of its priority group.
- R8: Terminate on the running task makes it suspended, and the next eligible ready task starts at the same edge.
- R9: Wait on the running task makes it waiting. A waiting task is never chosen to run.
- R10: Release on a waiting task makes it ready as the youngest member of its priority group. It may start, or preempt, at that same edge.
- R11: Each of the following is ignored and raises `cmd_err` for one cycle: activate on a task that is not suspended, terminate or wait on a task that is not running, release on a task that is not waiting, and any task index at or beyond the task count.
- R12: When no task is ready or running, `run_valid` is low and `run_id` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; priorities are sampled while high |
| prio_init | input | NUM_TASKS*PRIO_W | Packed static priority per task |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code (0 activate, 1 terminate, 2 wait, 3 release) |
| cmd_task | input | ID_W | Task index the command targets |
| run_valid | output | 1 | A task is running |
| run_id | output | ID_W | Index of the running task |
| preempt | output | 1 | One-cycle pulse when a running task was displaced |
| cmd_err | output | 1 | One-cycle pulse for an illegal command |

## Verification
The hardest situation to reach is a tie between equal-priority tasks where arrival order is not the order of activation. This arises when a task re-enters ready through preemption or release while an equal peer is already queued. The stimulus builds this deliberately. One sequence has a high-priority task displace a low-priority runner while a same-priority peer waits, then terminates the intruder and observes which peer resumes. A second sequence parks a task in waiting, activates two peers of its priority, releases it, and then retires the runners one at a time to read the queue order at `run_id`.

// File: rtl/task_sched_pkg.sv
package task_sched_pkg;

  typedef enum logic [1:0] {
    ST_SUSP  = 2'd0,
    ST_READY = 2'd1,
    ST_RUN   = 2'd2,
    ST_WAIT  = 2'd3
  } task_state_e;

  typedef enum logic [1:0] {
    OP_ACTIVATE  = 2'd0,
    OP_TERMINATE = 2'd1,
    OP_WAIT      = 2'd2,
    OP_RELEASE   = 2'd3
  } cmd_op_e;

endpackage

// File: rtl/sched_age_order.sv
// Pairwise age relation: older[i][j] = 1 when task i entered ready before task j.
// Two ordered entry sources per cycle: commands first, then preemption,
// so a preempted task is always younger than a task released in the same cycle.
module sched_age_order #(
  parameter int NUM_TASKS = 8
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [NUM_TASKS-1:0]                 enter_cmd,
  input  logic [NUM_TASKS-1:0]                 enter_pre,
  output logic [NUM_TASKS-1:0][NUM_TASKS-1:0]  order_mid
);

  typedef logic [NUM_TASKS-1:0][NUM_TASKS-1:0] age_mat_t;

  age_mat_t order_q;
  age_mat_t order_nxt;

  function automatic age_mat_t mark_youngest(input age_mat_t m,
                                             input logic [NUM_TASKS-1:0] e);
    age_mat_t r;
    for (int i = 0; i < NUM_TASKS; i++) begin
      for (int j = 0; j < NUM_TASKS; j++) begin
        if (i == j)      r[i][j] = 1'b0;
        else if (e[j])   r[i][j] = 1'b1;
        else if (e[i])   r[i][j] = 1'b0;
        else             r[i][j] = m[i][j];
      end
    end
    return r;
  endfunction

  always_comb begin
    order_mid = mark_youngest(order_q, enter_cmd);
    order_nxt = mark_youngest(order_mid, enter_pre);
  end

  always_ff @(posedge clk) begin
    if (rst) order_q <= '0;
    else     order_q <= order_nxt;
  end

  // R7: a preempted task ends up younger than every other task after the edge
  generate
    for (genvar g = 0; g < NUM_TASKS; g++) begin : g_age_chk
      assert_preempted_youngest_R7: assert property (@(posedge clk) disable iff (rst)
        enter_pre[g] |=> (order_q[g] == '0));
    end
  endgenerate

endmodule

// File: rtl/sched_pick.sv
// Combinational winner search: highest priority, then oldest among equals.
module sched_pick #(
  parameter int NUM_TASKS = 8,
  parameter int PRIO_W    = 3,
  localparam int ID_W     = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1
) (
  input  logic [NUM_TASKS-1:0]                 ready,
  input  logic [NUM_TASKS-1:0][PRIO_W-1:0]     prio,
  input  logic [NUM_TASKS-1:0][NUM_TASKS-1:0]  older,
  output logic                                 found,
  output logic [ID_W-1:0]                      win_id
);

  logic [NUM_TASKS-1:0] beats_all;

  generate
    for (genvar i = 0; i < NUM_TASKS; i++) begin : g_cand
      always_comb begin
        beats_all[i] = ready[i];
        for (int j = 0; j < NUM_TASKS; j++) begin
          if (j != i && ready[j]) begin
            if (prio[i] < prio[j])
              beats_all[i] = 1'b0;
            else if (prio[i] == prio[j] && !older[i][j])
              beats_all[i] = 1'b0;
          end
        end
      end
    end
  endgenerate

  always_comb begin
    found  = |beats_all;
    win_id = '0;
    for (int i = 0; i < NUM_TASKS; i++) begin
      if (beats_all[i]) win_id = ID_W'(i);
    end
  end

endmodule

// File: rtl/task_scheduler.sv
module task_scheduler
  import task_sched_pkg::*;
#(
  parameter int NUM_TASKS = 8,
  parameter int PRIO_W    = 3,
  localparam int ID_W     = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_TASKS*PRIO_W-1:0]   prio_init,
  input  logic                          cmd_valid,
  input  logic [1:0]                    cmd_op,
  input  logic [ID_W-1:0]               cmd_task,
  output logic                          run_valid,
  output logic [ID_W-1:0]               run_id,
  output logic                          preempt,
  output logic                          cmd_err
);

  task_state_e st_q [NUM_TASKS];
  task_state_e st_a [NUM_TASKS];
  task_state_e st_n [NUM_TASKS];

  logic [NUM_TASKS-1:0][PRIO_W-1:0]    prio_q;
  logic [NUM_TASKS-1:0][NUM_TASKS-1:0] order_mid;
  logic [NUM_TASKS-1:0]                enter_cmd, enter_pre, ready_a;
  logic                                err_n, has_run, found, start, pre_n;
  logic [ID_W-1:0]                     cur_id, win_id;
  logic                                run_valid_n;
  logic [ID_W-1:0]                     run_id_n;
  logic [NUM_TASKS-1:0]                run_mask_q;
  cmd_op_e                             op;
  logic                                idx_ok;

  assign op     = cmd_op_e'(cmd_op);
  assign idx_ok = int'(cmd_task) < NUM_TASKS;

  // Priorities are latched while reset is held (R1)
  always_ff @(posedge clk) begin
    if (rst) prio_q <= prio_init;
  end

  // Stage 1: apply the command to the current state
  always_comb begin
    for (int i = 0; i < NUM_TASKS; i++) st_a[i] = st_q[i];
    enter_cmd = '0;
    err_n     = 1'b0;
    if (cmd_valid) begin
      if (!idx_ok) begin
        err_n = 1'b1;
      end else begin
        unique case (op)
          OP_ACTIVATE: begin
            if (st_q[cmd_task] == ST_SUSP) begin
              st_a[cmd_task]      = ST_READY;
              enter_cmd[cmd_task] = 1'b1;
            end else err_n = 1'b1;
          end
          OP_TERMINATE: begin
            if (st_q[cmd_task] == ST_RUN) st_a[cmd_task] = ST_SUSP;
            else err_n = 1'b1;
          end
          OP_WAIT: begin
            if (st_q[cmd_task] == ST_RUN) st_a[cmd_task] = ST_WAIT;
            else err_n = 1'b1;
          end
          OP_RELEASE: begin
            if (st_q[cmd_task] == ST_WAIT) begin
              st_a[cmd_task]      = ST_READY;
              enter_cmd[cmd_task] = 1'b1;
            end else err_n = 1'b1;
          end
          default: err_n = 1'b1;
        endcase
      end
    end
  end

  always_comb begin
    has_run = 1'b0;
    cur_id  = '0;
    for (int i = 0; i < NUM_TASKS; i++) begin
      ready_a[i] = (st_a[i] == ST_READY);
      if (st_a[i] == ST_RUN) begin
        has_run = 1'b1;
        cur_id  = ID_W'(i);
      end
    end
  end

  sched_age_order #(
    .NUM_TASKS (NUM_TASKS)
  ) i_age (
    .clk       (clk),
    .rst       (rst),
    .enter_cmd (enter_cmd),
    .enter_pre (enter_pre),
    .order_mid (order_mid)
  );

  sched_pick #(
    .NUM_TASKS (NUM_TASKS),
    .PRIO_W    (PRIO_W)
  ) i_pick (
    .ready  (ready_a),
    .prio   (prio_q),
    .older  (order_mid),
    .found  (found),
    .win_id (win_id)
  );

  // Stage 2: dispatch decision
  always_comb begin
    for (int i = 0; i < NUM_TASKS; i++) st_n[i] = st_a[i];
    enter_pre = '0;
    pre_n     = 1'b0;
    start     = 1'b0;
    if (found) begin
      if (!has_run) start = 1'b1;
      else if (prio_q[win_id] > prio_q[cur_id]) begin
        start             = 1'b1;
        pre_n             = 1'b1;
        st_n[cur_id]      = ST_READY;
        enter_pre[cur_id] = 1'b1;
      end
    end
    if (start) st_n[win_id] = ST_RUN;
    run_valid_n = has_run | found;
    run_id_n    = start ? win_id : cur_id;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_TASKS; i++) st_q[i] <= ST_SUSP;
      run_valid <= 1'b0;
      run_id    <= '0;
      preempt   <= 1'b0;
      cmd_err   <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_TASKS; i++) st_q[i] <= st_n[i];
      run_valid <= run_valid_n;
      run_id    <= run_id_n;
      preempt   <= pre_n;
      cmd_err   <= err_n;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_TASKS; i++) run_mask_q[i] = (st_q[i] == ST_RUN);
  end

  assert_single_runner_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(run_mask_q));

  assert_preempt_switches_R6: assert property (@(posedge clk) disable iff (rst)
    preempt |-> (run_valid && run_id != $past(run_id)));

  assert_bad_activate_flag_R11: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && op == OP_ACTIVATE && idx_ok && st_q[cmd_task] != ST_SUSP)
      |=> (cmd_err && $stable(run_id)));

  generate
    for (genvar g = 0; g < NUM_TASKS; g++) begin : g_task_chk
      assert_no_higher_ready_R4: assert property (@(posedge clk) disable iff (rst)
        (st_q[g] == ST_READY && run_valid) |-> (prio_q[g] <= prio_q[run_id]));

      assert_waiting_held_R9: assert property (@(posedge clk) disable iff (rst)
        (st_q[g] == ST_WAIT &&
         !(cmd_valid && op == OP_RELEASE && int'(cmd_task) == g))
          |=> (st_q[g] == ST_WAIT));
    end
  endgenerate

endmodule

// File: tb/test_task_scheduler.sv
module test_task_scheduler;

  localparam int N  = 8;
  localparam int PW = 3;
  localparam int IW = 3;

  localparam logic [1:0] ACT = 2'd0, TRM = 2'd1, WAI = 2'd2, REL = 2'd3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N*PW-1:0] prio_init;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = '0;
  logic [IW-1:0] cmd_task = '0;
  logic          run_valid, preempt, cmd_err;
  logic [IW-1:0] run_id;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  task_scheduler #(.NUM_TASKS(N), .PRIO_W(PW)) i_task_scheduler (
    .clk       (clk),
    .rst       (rst),
    .prio_init (prio_init),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_task  (cmd_task),
    .run_valid (run_valid),
    .run_id    (run_id),
    .preempt   (preempt),
    .cmd_err   (cmd_err)
  );

  // Priorities: t0=1 t1=1 t2=3 t3=5 t4=5 t5=7 t6=1 t7=3
  initial begin
    prio_init = {3'd3, 3'd1, 3'd7, 3'd5, 3'd5, 3'd3, 3'd1, 3'd1};
  end

  task automatic expect_out(input logic v, input logic [IW-1:0] id,
                            input logic p, input logic e, input string tag);
    checks++;
    if (run_valid !== v || (v && run_id !== id) || (!v && run_id !== '0) ||
        preempt !== p || cmd_err !== e) begin
      errors++;
      $display("FAIL %s: got valid=%0b id=%0d pre=%0b err=%0b, expected valid=%0b id=%0d pre=%0b err=%0b",
               tag, run_valid, run_id, preempt, cmd_err, v, v ? id : 3'd0, p, e);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    cmd_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic issue(input logic [1:0] op, input int t);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_task  = IW'(t);
    @(posedge clk);
    #1 cmd_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle_cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset();
    expect_out(1'b0, 0, 1'b0, 1'b0, "R1 reset state");
    idle_cycle();
    expect_out(1'b0, 0, 1'b0, 1'b0, "R12 idle with nothing ready");
  endtask

  task automatic t_priority();
    do_reset();
    issue(ACT, 0);
    expect_out(1'b1, 0, 1'b0, 1'b0, "R2 activate starts t0");
    issue(ACT, 3);
    expect_out(1'b1, 3, 1'b1, 1'b0, "R6 higher prio preempts");
    idle_cycle();
    expect_out(1'b1, 3, 1'b0, 1'b0, "R6 preempt pulse one cycle");
    issue(ACT, 4);
    expect_out(1'b1, 3, 1'b0, 1'b0, "R6 equal prio no preempt");
    issue(ACT, 2);
    expect_out(1'b1, 3, 1'b0, 1'b0, "R6 lower prio no preempt");
    issue(ACT, 5);
    expect_out(1'b1, 5, 1'b1, 1'b0, "R4 top prio preempts");
    issue(TRM, 5);
    expect_out(1'b1, 4, 1'b0, 1'b0, "R7 preempted t3 behind t4");
    issue(TRM, 4);
    expect_out(1'b1, 3, 1'b0, 1'b0, "R8 terminate picks t3");
    issue(TRM, 3);
    expect_out(1'b1, 2, 1'b0, 1'b0, "R4 prio 3 over prio 1");
    issue(TRM, 2);
    expect_out(1'b1, 0, 1'b0, 1'b0, "R8 terminate picks t0");
    issue(TRM, 0);
    expect_out(1'b0, 0, 1'b0, 1'b0, "R12 idle after last terminate");
  endtask

  task automatic t_fifo();
    do_reset();
    issue(ACT, 2);
    issue(ACT, 1);
    issue(ACT, 0);
    expect_out(1'b1, 2, 1'b0, 1'b0, "R5 runner kept");
    issue(TRM, 2);
    expect_out(1'b1, 1, 1'b0, 1'b0, "R5 older t1 first");
    issue(TRM, 1);
    expect_out(1'b1, 0, 1'b0, 1'b0, "R5 then t0");
    do_reset();
    issue(ACT, 7);
    issue(ACT, 0);
    issue(ACT, 1);
    issue(TRM, 7);
    expect_out(1'b1, 0, 1'b0, 1'b0, "R5 older t0 first");
  endtask

  task automatic t_tail();
    do_reset();
    issue(ACT, 0);
    issue(ACT, 1);
    issue(ACT, 3);
    expect_out(1'b1, 3, 1'b1, 1'b0, "R6 t3 preempts t0");
    issue(TRM, 3);
    expect_out(1'b1, 1, 1'b0, 1'b0, "R7 preempted t0 at tail");
    issue(TRM, 1);
    expect_out(1'b1, 0, 1'b0, 1'b0, "R7 t0 after t1");
  endtask

  task automatic t_wait_release();
    do_reset();
    issue(ACT, 3);
    issue(ACT, 0);
    issue(WAI, 3);
    expect_out(1'b1, 0, 1'b0, 1'b0, "R9 wait hands over to t0");
    issue(TRM, 0);
    expect_out(1'b0, 0, 1'b0, 1'b0, "R9 waiting task not chosen");
    idle_cycle();
    expect_out(1'b0, 0, 1'b0, 1'b0, "R9 still idle");
    issue(REL, 3);
    expect_out(1'b1, 3, 1'b0, 1'b0, "R10 release starts t3");
    issue(ACT, 0);
    issue(WAI, 3);
    expect_out(1'b1, 0, 1'b0, 1'b0, "R9 t0 runs while t3 waits");
    issue(REL, 3);
    expect_out(1'b1, 3, 1'b1, 1'b0, "R10 release preempts");
    do_reset();
    issue(ACT, 0);
    issue(WAI, 0);
    expect_out(1'b0, 0, 1'b0, 1'b0, "R9 lone waiter leaves idle");
    issue(ACT, 6);
    issue(ACT, 1);
    issue(REL, 0);
    expect_out(1'b1, 6, 1'b0, 1'b0, "R10 release equal prio no preempt");
    issue(TRM, 6);
    expect_out(1'b1, 1, 1'b0, 1'b0, "R10 released t0 is youngest");
    issue(TRM, 1);
    expect_out(1'b1, 0, 1'b0, 1'b0, "R10 t0 last");
  endtask

  task automatic t_errors();
    do_reset();
    issue(ACT, 2);
    expect_out(1'b1, 2, 1'b0, 1'b0, "R2 t2 runs");
    issue(ACT, 2);
    expect_out(1'b1, 2, 1'b0, 1'b1, "R11 activate of running task");
    idle_cycle();
    expect_out(1'b1, 2, 1'b0, 1'b0, "R11 flag lasts one cycle");
    issue(TRM, 5);
    expect_out(1'b1, 2, 1'b0, 1'b1, "R11 terminate of suspended task");
    issue(WAI, 0);
    expect_out(1'b1, 2, 1'b0, 1'b1, "R11 wait of suspended task");
    issue(REL, 2);
    expect_out(1'b1, 2, 1'b0, 1'b1, "R11 release of running task");
    issue(ACT, 6);
    issue(WAI, 6);
    expect_out(1'b1, 2, 1'b0, 1'b1, "R11 wait of ready task");
    issue(TRM, 2);
    expect_out(1'b1, 6, 1'b0, 1'b0, "R11 ignored wait left t6 ready");
    issue(TRM, 6);
    expect_out(1'b0, 0, 1'b0, 1'b0, "R12 idle again");
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset_state();
    t_priority();
    t_fifo();
    t_tail();
    t_wait_release();
    t_errors();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule